// File: doc/BRIEF.md
# Per-Area External Bus Wait Controller

This block times bus cycles for an external memory interface whose address space is split into eight areas. Three 8-bit registers control the timing, and software reads and writes them through a small register port. The first register holds one bit per area that picks two-state or three-state access. The other two registers hold a 2-bit wait count for every area. When a requester raises a request, it also supplies the area number and two flags: one marks the access as on-chip and one marks the area as DRAM space. The block then steps through the access states, inserts the programmed wait states when they apply, and pulses a done flag in the last state.

Wait states are inserted only in three-state areas. They fall between the second and the third state. On-chip accesses and DRAM areas always take a fixed two-state cycle with no waits, whatever the registers hold. Hardware standby sets all three registers back to all-ones and aborts any access in flight. Software standby keeps the register contents. While it is active, no new access starts, but an access already running is allowed to finish.

Top module: `ext_bus_wait_ctrl`

## Requirements
- R1: After reset all three registers read 8'hFF, `acc_busy` and `acc_done` are 0 and `acc_phase` is idle (0).
- R2: An external, non-DRAM access to an area whose access-state bit is 0 takes two busy cycles, phase 1 then phase 2. `acc_done` is high only in phase 2 and no wait state appears, whatever that area's wait field holds.
- R3: An external, non-DRAM access to an area whose access-state bit is 1 runs phase 1 and phase 2, then N wait cycles (phase 3, `acc_wait` high), then phase 4. N is the area's wait field. The access is 3+N busy cycles long and `acc_done` is high only in phase 4.
- R4: Register address 0 is the access-state register, and bit n controls area n. Address 1 holds the wait fields for areas 7..4 and address 2 holds those for areas 3..0. Each area has a 2-bit field, and the higher area sits in the upper bits. For example, area 7 is address 1 bits [7:6] and area 0 is address 2 bits [1:0].
- R5: An access with `acc_onchip` high takes two busy cycles with no wait state, independent of all register settings.
- R6: An access with `acc_dram` high takes two busy cycles with no wait state, independent of that area's access-state bit and wait field.
- R7: Addresses 0, 1 and 2 read back the last value written. Address 3 reads 0, and a write to address 3 changes no register.
- R8: While `hw_stby` is high, all three registers are forced to 8'hFF, register writes are ignored and the sequencer returns to idle.
- R9: `sw_stby` leaves all register contents unchanged. While it is high, no new access starts, and an access already in progress runs to completion.
- R10: A request is accepted only in idle. A request held high through an access starts the next access only after the block has spent one cycle in idle. The timing settings are captured at the acceptance edge, so a register write in that same cycle applies only to later accesses.
- R11: `acc_done` is a one-cycle pulse per access in its final state, and the block is idle in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| hw_stby | input | 1 | Hardware standby: registers to all-ones, sequencer idle |
| sw_stby | input | 1 | Software standby: registers kept, new accesses held off |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 access-state, 1 wait high, 2 wait low) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| acc_req | input | 1 | Access request, level sensitive |
| acc_area | input | 3 | Area number of the request |
| acc_onchip | input | 1 | Request targets on-chip memory or registers |
| acc_dram | input | 1 | Requested area is DRAM space |
| acc_busy | output | 1 | An access is in progress |
| acc_phase | output | 3 | 0 idle, 1 first state, 2 second state, 3 wait, 4 third state |
| acc_wait | output | 1 | A wait state is being inserted |
| acc_done | output | 1 | Final state of the current access |

## Verification
Two things can happen in the same clock edge: a register write and the acceptance of a new access whose timing that write would change. The bench sets area 0 to three states with three waits. It then raises the request and a write that clears the access-state register at the same falling edge. The access must still run the six-cycle, three-wait sequence, and the register must read back the new value. A second access to the same area must then take two cycles, which shows the write landed for later accesses only.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_TW   = 3'd3,
      PH_T3   = 3'd4
   } phase_e;

   // register map: timing-select register first, then wait registers high to low
   localparam int ADDR_SEL = 0;

endpackage

// File: rtl/ebw_regfile.sv
module ebw_regfile #(
   parameter int REG_W  = 8,
   parameter int AREAS  = 8,
   parameter int WAIT_W = 2,
   parameter int ADDR_W = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      hw_stby,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [REG_W-1:0]          wdata,
   output logic [REG_W-1:0]          rdata,
   output logic [AREAS-1:0]          sel_o,
   output logic [AREAS*WAIT_W-1:0]   wait_o
);
   import ebw_pkg::*;

   localparam int NUM_WREG = (AREAS * WAIT_W) / REG_W;
   localparam int LAST_ADR = NUM_WREG;

   if (AREAS != REG_W) begin : g_bad_sel
      $error("one select bit per area requires AREAS == REG_W");
   end
   if ((AREAS * WAIT_W) % REG_W != 0) begin : g_bad_wait
      $error("wait fields must fill whole registers");
   end
   if ((1 << ADDR_W) < NUM_WREG + 1) begin : g_bad_addr
      $error("address width too small for register count");
   end

   logic [REG_W-1:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= '1;
      else if (hw_stby)
         sel_q <= '1;
      else if (we && addr == ADDR_W'(ADDR_SEL))
         sel_q <= wdata;
   end

   assign sel_o = sel_q;

   // wait register i covers areas i*REG_W/WAIT_W upward; highest index at lowest address
   for (genvar i = 0; i < NUM_WREG; i++) begin : g_wreg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '1;
         else if (hw_stby)
            q <= '1;
         else if (we && addr == ADDR_W'(NUM_WREG - i))
            q <= wdata;
      end
      assign wait_o[i*REG_W +: REG_W] = q;
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADDR_SEL))
         rdata = sel_q;
      for (int i = 0; i < NUM_WREG; i++) begin
         if (addr == ADDR_W'(NUM_WREG - i))
            rdata = wait_o[i*REG_W +: REG_W];
      end
   end

   // R8
   hw_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |=> (sel_q == '1 && wait_o == '1));

   // R7
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !hw_stby && addr > ADDR_W'(LAST_ADR)) |=> ($stable(sel_q) && $stable(wait_o)));

endmodule

// File: rtl/ebw_timing_sel.sv
module ebw_timing_sel #(
   parameter int AREAS  = 8,
   parameter int WAIT_W = 2,
   parameter int AREA_W = $clog2(AREAS)
) (
   input  logic [AREAS-1:0]        sel,
   input  logic [AREAS*WAIT_W-1:0] waits,
   input  logic [AREA_W-1:0]       area,
   input  logic                    onchip,
   input  logic                    dram,
   output logic                    three_state,
   output logic [WAIT_W-1:0]       wait_n
);

   if (AREAS < 2) begin : g_bad_areas
      $error("at least two areas are required");
   end

   logic [WAIT_W-1:0] fld [AREAS];

   for (genvar a = 0; a < AREAS; a++) begin : g_fld
      assign fld[a] = waits[a*WAIT_W +: WAIT_W];
   end

   logic external;

   always_comb begin
      external    = !onchip && !dram;
      three_state = external && sel[area];
      wait_n      = three_state ? fld[area] : '0;
   end

endmodule

// File: rtl/ebw_seq.sv
module ebw_seq #(
   parameter int WAIT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              sw_stby,
   input  logic              req,
   input  logic              three_in,
   input  logic [WAIT_W-1:0] wait_in,
   output ebw_pkg::phase_e   phase,
   output logic              done
);
   import ebw_pkg::*;

   phase_e            phase_q;
   logic              three_q;
   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         three_q <= 1'b0;
         cnt_q   <= '0;
      end else if (hw_stby) begin
         phase_q <= PH_IDLE;
         three_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: if (req && !sw_stby) begin
               phase_q <= PH_T1;
               three_q <= three_in;
               cnt_q   <= wait_in;
            end
            PH_T1: phase_q <= PH_T2;
            PH_T2: begin
               if (!three_q)
                  phase_q <= PH_IDLE;
               else if (cnt_q != '0) begin
                  phase_q <= PH_TW;
                  cnt_q   <= cnt_q - 1'b1;
               end else
                  phase_q <= PH_T3;
            end
            PH_TW: begin
               if (cnt_q == '0)
                  phase_q <= PH_T3;
               else
                  cnt_q <= cnt_q - 1'b1;
            end
            PH_T3: phase_q <= PH_IDLE;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase = phase_q;
   assign done  = (phase_q == PH_T2 && !three_q) || (phase_q == PH_T3);

   // R3
   wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n || hw_stby)
      (phase_q == PH_TW) |=> (phase_q == PH_TW || phase_q == PH_T3));

   // R11
   done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || hw_stby)
      done |=> (phase_q == PH_IDLE));

   // R9
   sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || hw_stby)
      (phase_q == PH_IDLE && sw_stby) |=> (phase_q == PH_IDLE));

   // R10
   start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || hw_stby)
      (phase_q != PH_IDLE && !done) |=> (phase_q != PH_IDLE && phase_q != PH_T1));

endmodule

// File: rtl/ext_bus_wait_ctrl.sv
module ext_bus_wait_ctrl #(
   parameter int REG_W  = 8,
   parameter int AREAS  = 8,
   parameter int WAIT_W = 2,
   parameter int ADDR_W = 2,
   parameter int AREA_W = $clog2(AREAS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_stby,
   input  logic              sw_stby,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              acc_req,
   input  logic [AREA_W-1:0] acc_area,
   input  logic              acc_onchip,
   input  logic              acc_dram,
   output logic              acc_busy,
   output logic [2:0]        acc_phase,
   output logic              acc_wait,
   output logic              acc_done
);
   import ebw_pkg::*;

   logic [AREAS-1:0]        sel;
   logic [AREAS*WAIT_W-1:0] waits;
   logic                    three_state;
   logic [WAIT_W-1:0]       wait_n;
   phase_e                  phase;

   ebw_regfile #(.REG_W(REG_W), .AREAS(AREAS), .WAIT_W(WAIT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_stby(hw_stby),
      .we     (reg_we),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .sel_o  (sel),
      .wait_o (waits)
   );

   ebw_timing_sel #(.AREAS(AREAS), .WAIT_W(WAIT_W), .AREA_W(AREA_W)) u_sel (
      .sel        (sel),
      .waits      (waits),
      .area       (acc_area),
      .onchip     (acc_onchip),
      .dram       (acc_dram),
      .three_state(three_state),
      .wait_n     (wait_n)
   );

   ebw_seq #(.WAIT_W(WAIT_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_stby (hw_stby),
      .sw_stby (sw_stby),
      .req     (acc_req),
      .three_in(three_state),
      .wait_in (wait_n),
      .phase   (phase),
      .done    (acc_done)
   );

   assign acc_phase = phase;
   assign acc_busy  = (phase != PH_IDLE);
   assign acc_wait  = (phase == PH_TW);

   // R2
   wait_needs_three_chk: assert property (@(posedge clk) disable iff (!rst_n || hw_stby)
      (acc_phase == 3'd2 && acc_done) |=> !acc_wait);

endmodule

// File: tb/ext_bus_wait_ctrl_bench.sv
module ext_bus_wait_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hw_stby = 1'b0, sw_stby = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic       acc_req = 1'b0;
   logic [2:0] acc_area = '0;
   logic       acc_onchip = 1'b0, acc_dram = 1'b0;
   logic       acc_busy, acc_wait, acc_done;
   logic [2:0] acc_phase;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;   // 250 MHz

   ext_bus_wait_ctrl u_ext_bus_wait_ctrl (
      .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .acc_req(acc_req), .acc_area(acc_area), .acc_onchip(acc_onchip), .acc_dram(acc_dram),
      .acc_busy(acc_busy), .acc_phase(acc_phase), .acc_wait(acc_wait), .acc_done(acc_done)
   );

   typedef struct packed {
      logic [7:0] sel;
      logic [7:0] wh;
      logic [7:0] wl;
      logic [2:0] area;
      logic       oc;
      logic       dr;
      logic [3:0] tot;
      logic [3:0] wts;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{8'hFF, 8'hFF, 8'hFF, 3'd0, 1'b0, 1'b0, 4'd6, 4'd3},  // R3 defaults
      '{8'h00, 8'hFF, 8'hFF, 3'd5, 1'b0, 1'b0, 4'd2, 4'd0},  // R2
      '{8'hA5, 8'h1B, 8'hE4, 3'd0, 1'b0, 1'b0, 4'd3, 4'd0},  // R4
      '{8'hA5, 8'h1B, 8'hE4, 3'd2, 1'b0, 1'b0, 4'd5, 4'd2},
      '{8'hA5, 8'h1B, 8'hE4, 3'd1, 1'b0, 1'b0, 4'd2, 4'd0},
      '{8'hA5, 8'h1B, 8'hE4, 3'd7, 1'b0, 1'b0, 4'd3, 4'd0},
      '{8'hA5, 8'h1B, 8'hE4, 3'd5, 1'b0, 1'b0, 4'd5, 4'd2},
      '{8'hA5, 8'h1B, 8'hE4, 3'd3, 1'b0, 1'b0, 4'd2, 4'd0},
      '{8'hFF, 8'h1B, 8'hE4, 3'd6, 1'b0, 1'b0, 4'd4, 4'd1},
      '{8'hFF, 8'h1B, 8'hE4, 3'd4, 1'b0, 1'b0, 4'd6, 4'd3},
      '{8'hFF, 8'h1B, 8'hE4, 3'd3, 1'b0, 1'b0, 4'd6, 4'd3},
      '{8'hFF, 8'hFF, 8'hFF, 3'd3, 1'b1, 1'b0, 4'd2, 4'd0},  // R5
      '{8'hFF, 8'hFF, 8'hFF, 3'd6, 1'b0, 1'b1, 4'd2, 4'd0},  // R6
      '{8'hFF, 8'hFF, 8'hFF, 3'd6, 1'b1, 1'b1, 4'd2, 4'd0}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   // measures the access started at the current negedge; inputs already set
   task automatic measure(output int tot, output int wts, output int dn, output bit dlast);
      @(negedge clk); acc_req = 1'b0; reg_we = 1'b0;
      tot = 0; wts = 0; dn = 0; dlast = 0;
      while (acc_busy && tot < 20) begin
         tot++;
         if (acc_wait) wts++;
         if (acc_done) begin dn++; dlast = 1; end else dlast = 0;
         @(negedge clk);
      end
   endtask

   task automatic run_access(input logic [2:0] a, input logic oc, input logic dr,
                             output int tot, output int wts, output int dn, output bit dlast);
      @(negedge clk); acc_req = 1'b1; acc_area = a; acc_onchip = oc; acc_dram = dr;
      measure(tot, wts, dn, dlast);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      int tot, wts, dn;
      bit dl;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(acc_busy == 1'b0 && acc_done == 1'b0 && acc_phase == 3'd0, "R1 idle after reset",
          acc_phase, 0);
      for (int a = 0; a < 3; a++) begin
         rd(2'(a), d);
         chk(d == 8'hFF, "R1 register reset value", d, 8'hFF);
      end

      // table of vectors: R2 R3 R4 R5 R6 R11
      for (int i = 0; i < NV; i++) begin
         wr(2'd0, VECS[i].sel);
         wr(2'd1, VECS[i].wh);
         wr(2'd2, VECS[i].wl);
         rd(2'd1, d);
         chk(d == VECS[i].wh, "R7 readback wait high", d, VECS[i].wh);
         run_access(VECS[i].area, VECS[i].oc, VECS[i].dr, tot, wts, dn, dl);
         chk(tot == int'(VECS[i].tot), $sformatf("R3/R2 vec %0d busy cycles", i), tot, VECS[i].tot);
         chk(wts == int'(VECS[i].wts), $sformatf("R4 vec %0d wait cycles", i), wts, VECS[i].wts);
         chk(dn == 1 && dl, $sformatf("R11 vec %0d single done in final state", i), dn, 1);
      end

      // R7 unmapped address
      wr(2'd0, 8'h3C);
      wr(2'd3, 8'h55);
      rd(2'd3, d);
      chk(d == 8'h00, "R7 address 3 reads zero", d, 0);
      rd(2'd0, d);
      chk(d == 8'h3C, "R7 address 3 write ignored", d, 8'h3C);

      // R10 write in the acceptance cycle applies only later
      wr(2'd0, 8'hFF);
      wr(2'd2, 8'hFF);
      @(negedge clk);
      acc_req = 1'b1; acc_area = 3'd0; acc_onchip = 1'b0; acc_dram = 1'b0;
      reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00;
      measure(tot, wts, dn, dl);
      chk(tot == 6 && wts == 3, "R10 same-cycle write uses old timing", tot, 6);
      rd(2'd0, d);
      chk(d == 8'h00, "R10 same-cycle write landed", d, 0);
      run_access(3'd0, 1'b0, 1'b0, tot, wts, dn, dl);
      chk(tot == 2 && wts == 0, "R10 next access uses new timing", tot, 2);

      // R10 held request: one idle cycle between accesses
      @(negedge clk); acc_req = 1'b1; acc_area = 3'd1;
      @(negedge clk);
      chk(acc_phase == 3'd1, "R10 first access phase 1", acc_phase, 1);
      @(negedge clk);
      chk(acc_phase == 3'd2 && acc_done, "R2 phase 2 done", acc_phase, 2);
      @(negedge clk);
      chk(acc_busy == 1'b0, "R10 idle gap between held requests", acc_busy, 0);
      @(negedge clk);
      chk(acc_phase == 3'd1, "R10 second access starts", acc_phase, 1);
      acc_req = 1'b0;
      repeat (3) @(negedge clk);

      // R8 hardware standby mid-access
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'h00);
      wr(2'd2, 8'hFF);
      @(negedge clk); acc_req = 1'b1; acc_area = 3'd2;
      @(negedge clk); acc_req = 1'b0;
      chk(acc_phase == 3'd1, "R8 access started", acc_phase, 1);
      hw_stby = 1'b1;
      reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h12;
      @(negedge clk);
      reg_we = 1'b0;
      chk(acc_busy == 1'b0, "R8 sequencer forced idle", acc_busy, 0);
      #1 chk(reg_rdata == 8'hFF, "R8 write ignored in standby", reg_rdata, 8'hFF);
      rd(2'd1, d);
      chk(d == 8'hFF, "R8 wait high forced to FF", d, 8'hFF);
      hw_stby = 1'b0;
      @(negedge clk);

      // R9 software standby
      wr(2'd0, 8'h0F);
      wr(2'd2, 8'h5A);
      @(negedge clk); sw_stby = 1'b1; acc_req = 1'b1; acc_area = 3'd0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(acc_busy == 1'b0, "R9 no start in software standby", acc_busy, 0);
      end
      rd(2'd0, d);
      chk(d == 8'h0F, "R9 select register kept", d, 8'h0F);
      rd(2'd2, d);
      chk(d == 8'h5A, "R9 wait low kept", d, 8'h5A);
      sw_stby = 1'b0;
      @(negedge clk);
      chk(acc_phase == 3'd1, "R9 held request starts after standby", acc_phase, 1);
      acc_req = 1'b0;
      // area 0: select 1, field 2 -> 5 cycles total; standby raised mid-access
      sw_stby = 1'b1;
      tot = 1; dn = 0;
      while (acc_busy && tot < 20) begin
         if (acc_done) dn++;
         @(negedge clk);
         if (acc_busy) tot++;
      end
      chk(tot == 5 && dn == 1, "R9 in-flight access completes", tot, 5);
      sw_stby = 1'b0;
      @(negedge clk);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule